// File: doc/BRIEF.md
# Warp Lane Shuffle Crossbar

This unit moves 32-bit register values between the lanes of one warp. Every lane gives one data word. Every lane also gets back the word of some source lane, and the source is picked by a shared operation code and a shared operand. The exchange uses a full crossbar, so no memory is involved. An operation is accepted in one cycle, and its results sit in one output register stage.

A run-time tile size splits the warp into aligned groups of `2^k` lanes. Every source lane is confined to the tile of the lane that asks for it. In indexed mode the operand wraps inside the tile. In the shift modes a lane keeps its own word when the shifted position would leave its tile. An active-lane mask freezes inactive lanes. For each lane, an invalid flag reports a result that was taken from an inactive lane.

The warp width is a parameter and defaults to 8 lanes.

Top module: `warp_shuffle_xbar`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1.
- R2: An operation is accepted on a rising edge when `inValid` and `inReady` are both 1. Its results appear with `outValid` = 1 one cycle after that edge.
- R3: While `outValid` is 1 and `outReady` is 0, `inReady` is 0 and `outValid` and `outData` hold their values. When `outReady` is 1, a new operation can be accepted in the same cycle that the old result is taken.
- R4: `inOp` = 0 selects indexed mode. An active lane i reads lane `base + (inOperand mod T)`, where T is the tile size and `base` is i rounded down to a multiple of T.
- R5: `inOp` = 1 selects down mode. An active lane i reads lane `i + inOperand` if `(i mod T) + inOperand < T`. Otherwise it returns its own word.
- R6: `inOp` = 2 selects up mode. An active lane i reads lane `i - inOperand` if `(i mod T) >= inOperand`. Otherwise it returns its own word.
- R7: T = 2^`inTileLog`. Any `inTileLog` above log2(LANES) is treated as a whole-warp tile.
- R8: A lane whose `inMask` bit is 0 returns its own input word, and its invalid flag is 0.
- R9: An active lane's invalid flag is 1 exactly when the source lane it read has mask bit 0.
- R10: `inOp` = 3 is a copy: every lane returns its own word.
- R11: Lane i uses bits `[32*i +: 32]` of `inData` and `outData`, and bit i of `inMask` and `outInvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An operation is offered |
| inReady | output | 1 | The unit can take an operation this cycle |
| inOp | input | 2 | Mode: 0 indexed, 1 down, 2 up, 3 copy |
| inMask | input | LANES | Active-lane mask |
| inOperand | input | log2(LANES) | Source index or shift distance |
| inTileLog | input | log2(LANES) | log2 of the tile size |
| inData | input | 32*LANES | One word per lane |
| outValid | output | 1 | Result register holds a result |
| outReady | input | 1 | Consumer takes the result |
| outData | output | 32*LANES | One result word per lane |
| outInvalid | output | LANES | Per-lane flag: result came from an inactive lane |

## Verification
Some properties are checked on every cycle. The output becomes valid after each acceptance. A stalled result keeps its valid flag and its data. An inactive lane always captures its own word with its flag clear.

The routing itself can only be shown by the bench's sweeps. These cover every mode, every tile size including the clamped values, every operand and several mask patterns, and each lane's word and flag is compared with an arithmetic model. The stall-and-replace sequence is also only shown by a directed scenario.

// File: rtl/wsx_pkg.sv
package wsx_pkg;

  typedef enum logic [1:0] {
    SHF_INDEX = 2'd0,
    SHF_DOWN  = 2'd1,
    SHF_UP    = 2'd2,
    SHF_COPY  = 2'd3
  } shfOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic selIndex;
    logic selDown;
    logic selUp;
  } xbarStrobe_t;

endpackage

// File: rtl/wsx_ctrl.sv
module wsx_ctrl
  import wsx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  inOp,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output xbarStrobe_t strobe
);

  logic   outValidQ;
  logic   accept;
  shfOp_e opCode;

  assign opCode  = shfOp_e'(inOp);
  assign inReady = !outValidQ || outReady;
  assign accept  = inValid && inReady;

  always_comb begin
    strobe          = '0;
    strobe.load     = accept;
    strobe.selIndex = (opCode == SHF_INDEX);
    strobe.selDown  = (opCode == SHF_DOWN);
    strobe.selUp    = (opCode == SHF_UP);
  end

  always_ff @(posedge clk) begin
    if (!rstN)         outValidQ <= 1'b0;
    else if (accept)   outValidQ <= 1'b1;
    else if (outReady) outValidQ <= 1'b0;
  end

  assign outValid = outValidQ;

  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid) else $error("accept without result"); // R2

  AST_STALL_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid) else $error("stalled result dropped"); // R3

endmodule

// File: rtl/wsx_datapath.sv
module wsx_datapath
  import wsx_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int DATA_W = 32,
  parameter int LANE_W = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  xbarStrobe_t               strobe,
  input  logic [LANES*DATA_W-1:0]   inData,
  input  logic [LANES-1:0]          inMask,
  input  logic [LANE_W-1:0]         inOperand,
  input  logic [LANE_W-1:0]         inTileLog,
  output logic [LANES*DATA_W-1:0]   outData,
  output logic [LANES-1:0]          outInvalid
);

  localparam int LOG_LANES = $clog2(LANES);

  logic [DATA_W-1:0] dataArr [LANES];
  logic [DATA_W-1:0] resData [LANES];
  logic [LANES-1:0]  resInv;
  logic [LANE_W-1:0] srcSel  [LANES];
  logic [LANE_W-1:0] tileLogEff;
  logic [LANE_W:0]   tileSize;
  logic [LANE_W-1:0] tileMask;

  // Clamp tile size to the whole warp
  always_comb begin
    if (inTileLog > LANE_W'(LOG_LANES)) tileLogEff = LANE_W'(LOG_LANES);
    else                                tileLogEff = inTileLog;
    tileSize = (LANE_W+1)'(1) << tileLogEff;
    tileMask = LANE_W'(tileSize - (LANE_W+1)'(1));
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] laneIdx;
    logic [LANE_W-1:0] tileBase;
    logic [LANE_W-1:0] tileOff;
    logic [LANE_W:0]   downSum;

    assign dataArr[i] = inData[i*DATA_W +: DATA_W];
    assign laneIdx    = LANE_W'(i);
    assign tileBase   = laneIdx & ~tileMask;
    assign tileOff    = laneIdx & tileMask;
    assign downSum    = {1'b0, tileOff} + {1'b0, inOperand};

    always_comb begin
      srcSel[i] = laneIdx;
      if (strobe.selIndex) begin
        srcSel[i] = tileBase | (inOperand & tileMask);
      end else if (strobe.selDown) begin
        if (downSum < tileSize) srcSel[i] = laneIdx + inOperand;
      end else if (strobe.selUp) begin
        if (tileOff >= inOperand) srcSel[i] = laneIdx - inOperand;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        resData[i] <= '0;
        resInv[i]  <= 1'b0;
      end else if (strobe.load) begin
        resData[i] <= inMask[i] ? dataArr[srcSel[i]] : dataArr[i];
        resInv[i]  <= inMask[i] && !inMask[srcSel[i]];
      end
    end

    assign outData[i*DATA_W +: DATA_W] = resData[i];

    AST_INACTIVE_OWN: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.load && !inMask[i]) |=> (resData[i] == $past(dataArr[i])) && !resInv[i])
      else $error("inactive lane altered"); // R8
  end

  assign outInvalid = resInv;

endmodule

// File: rtl/warp_shuffle_xbar.sv
module warp_shuffle_xbar
  import wsx_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int DATA_W = 32,
  localparam int LANE_W = ($clog2(LANES) < 1) ? 1 : $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [1:0]              inOp,
  input  logic [LANES-1:0]        inMask,
  input  logic [LANE_W-1:0]       inOperand,
  input  logic [LANE_W-1:0]       inTileLog,
  input  logic [LANES*DATA_W-1:0] inData,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [LANES*DATA_W-1:0] outData,
  output logic [LANES-1:0]        outInvalid
);

  xbarStrobe_t strobe;

  wsx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inOp     (inOp),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  wsx_datapath #(
    .LANES  (LANES),
    .DATA_W (DATA_W),
    .LANE_W (LANE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inData     (inData),
    .inMask     (inMask),
    .inOperand  (inOperand),
    .inTileLog  (inTileLog),
    .outData    (outData),
    .outInvalid (outInvalid)
  );

  AST_STALL_DATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outData) && $stable(outInvalid))
    else $error("stalled data changed"); // R3

endmodule

// File: tb/warp_shuffle_xbar_test.sv
`timescale 1ns/1ps
module warp_shuffle_xbar_test;

  localparam int LANES  = 8;
  localparam int DATA_W = 32;
  localparam int LW     = 3;
  localparam int LOGL   = 3;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    inValid = 1'b0;
  logic                    inReady;
  logic [1:0]              inOp = '0;
  logic [LANES-1:0]        inMask = '0;
  logic [LW-1:0]           inOperand = '0;
  logic [LW-1:0]           inTileLog = '0;
  logic [LANES*DATA_W-1:0] inData = '0;
  logic                    outValid;
  logic                    outReady = 1'b1;
  logic [LANES*DATA_W-1:0] outData;
  logic [LANES-1:0]        outInvalid;

  int vecCount = 0;
  int missCount = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] expData [LANES];
  logic              expInv  [LANES];

  always #4 clk = ~clk;

  warp_shuffle_xbar #(.LANES(LANES), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inOp(inOp), .inMask(inMask), .inOperand(inOperand), .inTileLog(inTileLog),
    .inData(inData), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outInvalid(outInvalid)
  );

  // Arithmetic reference (R4..R11)
  task automatic computeExpected(input int op, input int tl, input int opnd,
                                 input logic [LANES-1:0] m,
                                 input logic [LANES*DATA_W-1:0] d);
    int t = (tl > LOGL) ? (1 << LOGL) : (1 << tl);
    for (int i = 0; i < LANES; i++) begin
      int base = (i / t) * t;
      int off  = i % t;
      int src  = i;
      if (op == 0) src = base + (opnd % t);
      else if (op == 1) src = (off + opnd < t) ? i + opnd : i;
      else if (op == 2) src = (off >= opnd) ? i - opnd : i;
      if (!m[i]) begin
        expData[i] = d[i*DATA_W +: DATA_W];
        expInv[i]  = 1'b0;
      end else begin
        expData[i] = d[src*DATA_W +: DATA_W];
        expInv[i]  = !m[src];
      end
    end
  endtask

  task automatic compareOut(input int op, input int tl, input string ctx);
    bit bad = 1'b0;
    vecCount++;
    if (outValid !== 1'b1) begin
      bad = 1'b1;
      $display("FAIL R2 %s: outValid=%b expected 1", ctx, outValid);
    end
    for (int i = 0; i < LANES; i++) begin
      string tag;
      if (outInvalid[i] !== expInv[i]) begin
        bad = 1'b1;
        $display("FAIL R9 %s lane %0d: invalid=%b expected %b", ctx, i, outInvalid[i], expInv[i]);
      end
      if (outData[i*DATA_W +: DATA_W] !== expData[i]) begin
        bad = 1'b1;
        if (!inMask[i]) tag = "R8";
        else if (tl > LOGL) tag = "R7";
        else if (op == 0) tag = "R4";
        else if (op == 1) tag = "R5";
        else if (op == 2) tag = "R6";
        else tag = "R10";
        $display("FAIL %s (R11) %s lane %0d: data=%h expected %h", tag, ctx, i,
                 outData[i*DATA_W +: DATA_W], expData[i]);
      end
    end
    if (bad) missCount++;
  endtask

  function automatic logic [LANES*DATA_W-1:0] makeData(input int seed);
    logic [LANES*DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++)
      r[i*DATA_W +: DATA_W] = 32'hA000_0000 + 32'(seed << 8) + 32'(i);
    return r;
  endfunction

  initial begin
    logic [LANES-1:0] masks [3];
    masks[0] = 8'hFF; masks[1] = 8'hA5; masks[2] = 8'h3C;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    vecCount++;
    if (outValid !== 1'b0 || inReady !== 1'b1) begin
      missCount++;
      $display("FAIL R1 reset: outValid=%b inReady=%b expected 0 1", outValid, inReady);
    end

    // Sweep of modes, tile sizes (with clamped values), operands, masks
    for (int op = 0; op < 4; op++)
      for (int tl = 0; tl < 6; tl++)
        for (int opnd = 0; opnd < LANES; opnd++)
          for (int mi = 0; mi < 3; mi++) begin
            int seed = ((op * 6 + tl) * 8 + opnd) * 3 + mi;
            inOp = 2'(op); inTileLog = LW'(tl); inOperand = LW'(opnd);
            inMask = masks[mi]; inData = makeData(seed); inValid = 1'b1;
            computeExpected(op, tl, opnd, masks[mi], inData);
            @(negedge clk);
            inValid = 1'b0;
            compareOut(op, tl, "sweep");
            @(negedge clk);
          end

    // R2: output drains after one idle cycle
    vecCount++;
    if (outValid !== 1'b0) begin
      missCount++;
      $display("FAIL R2 drain: outValid=%b expected 0", outValid);
    end

    // R3 stall: first result held, second waits
    outReady = 1'b0;
    inOp = 2'd1; inTileLog = 3'd2; inOperand = 3'd1; inMask = 8'hFF;
    inData = makeData(900); inValid = 1'b1;
    computeExpected(1, 2, 1, 8'hFF, inData);
    @(negedge clk);
    inOp = 2'd2; inTileLog = 3'd3; inOperand = 3'd3; inMask = 8'hF0;
    inData = makeData(901);
    vecCount++;
    if (inReady !== 1'b0) begin
      missCount++;
      $display("FAIL R3 stall: inReady=%b expected 0", inReady);
    end
    @(negedge clk);
    compareOut(1, 2, "stall-hold R3");
    outReady = 1'b1;
    computeExpected(2, 3, 3, 8'hF0, inData);
    @(negedge clk);
    inValid = 1'b0;
    compareOut(2, 3, "replace R3");
    @(negedge clk);
    vecCount++;
    if (outValid !== 1'b0) begin
      missCount++;
      $display("FAIL R3 after replace: outValid=%b expected 0", outValid);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      vecCount++;
      missCount++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

endmodule